// File: doc/BRIEF.md
# Presettable Binary Down Counter

This block is a synchronous binary down counter, eight bits wide by default, whose terminal-count output is active low. It is used as a divide-by-n stage or as a programmable timer. The counter decrements on every rising clock edge while its active-low count enable is asserted. After zero it wraps to the all-ones value, so a free-running counter repeats every 2^W clocks. Every control input is active low.

Four control inputs fix the operating mode, and the decode follows a fixed priority. Master reset is highest: it drives the register to all ones asynchronously. Next is the asynchronous preset, which forces the jam word into the register without waiting for a clock edge and tracks that word for as long as the strobe is held low. Next is the synchronous preset, which loads the jam word on the next rising edge whatever the enable is. When none of these is asserted, the counter either decrements or holds, depending on the enable. The terminal-count output is combinational from the count and the enable. A second instance can therefore take it directly as its enable in the same cycle, which builds a wider counter from several stages.

The mode decoder names five modes. MD_CLEAR is master reset. MD_APRE is the asynchronous preset. MD_SPRE is the synchronous preset. MD_COUNT decrements and MD_HOLD holds. Moving from one mode to another is purely a function of the control inputs at that moment: CLEAR beats APRE, APRE beats SPRE, SPRE beats COUNT, and COUNT or HOLD follows from the enable.

Top module: `dcnt_core`

## Requirements
- R1: With master reset, both presets high and count enable low, each rising clock edge lowers the count by one.
- R2: With master reset, both presets and count enable all high, the count does not change across clock edges.
- R3: While the synchronous preset is low (asynchronous preset and master reset high), the next rising edge loads the jam word. The enable makes no difference to this, and nothing changes before that edge.
- R4: While the asynchronous preset is low and master reset is high, the count equals the jam word without any clock edge. It follows later changes of the jam word and is unaffected by clock edges.
- R5: While master reset is low, the count is all ones (255 at W=8) at once and stays there whatever the other inputs do.
- R6: Priority is master reset over asynchronous preset, asynchronous preset over synchronous preset, and synchronous preset over count/hold.
- R7: The terminal-count output is low exactly when the count is zero and the count enable is low. It follows the enable combinationally and is low for one clock period while counting.
- R8: When counting, a count of zero becomes all ones on the next edge, so one full free-running cycle is 256 clocks at W=8 and contains exactly one terminal-count period.
- R9: Bit W-1 of the jam word and of the count is the most significant. If the terminal-count output of a lower stage drives the count enable of an upper stage, the pair counts down as one 2W-bit binary counter, and the upper stage decrements only on the edge where the lower stage wraps from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| mrst_n_i | input | 1 | Asynchronous master reset to all ones, active low |
| apre_n_i | input | 1 | Asynchronous preset strobe, active low |
| spre_n_i | input | 1 | Synchronous preset strobe, active low |
| cen_n_i | input | 1 | Count enable, active low; also gates the terminal count |
| jam_i | input | W | Preset word, bit W-1 most significant |
| count_o | output | W | Current count |
| zero_n_o | output | 1 | Terminal count, active low |

## Verification
The clocked properties depend on the asynchronous strobes and master reset being either held across a rising edge or left alone. A strobe pulse that begins and ends between two edges would change the count in a way that the edge-to-edge properties do not model. For that reason the bench changes every control and the jam word only on falling edges. Each time it asserts the asynchronous preset or master reset, it keeps the signal low through at least one rising edge. The jam word is still changed in the middle of a cycle while the asynchronous preset is low, which exercises the tracking behaviour without breaking that rule.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;

    typedef enum logic [2:0] {
        MD_CLEAR = 3'd0,
        MD_APRE  = 3'd1,
        MD_SPRE  = 3'd2,
        MD_COUNT = 3'd3,
        MD_HOLD  = 3'd4
    } dcnt_mode_e;

endpackage

// File: rtl/dcnt_mode_dec.sv
module dcnt_mode_dec
    import dcnt_pkg::*;
(
    input  logic       mrst_n_i,
    input  logic       apre_n_i,
    input  logic       spre_n_i,
    input  logic       cen_n_i,
    output dcnt_mode_e mode_o
);

    // Fixed precedence: clear, async preset, sync preset, count/hold
    always_comb begin
        if (!mrst_n_i)      mode_o = MD_CLEAR;
        else if (!apre_n_i) mode_o = MD_APRE;
        else if (!spre_n_i) mode_o = MD_SPRE;
        else if (!cen_n_i)  mode_o = MD_COUNT;
        else                mode_o = MD_HOLD;
    end

endmodule

// File: rtl/dcnt_bit.sv
module dcnt_bit (
    input  logic clk_i,
    input  logic set_i,
    input  logic clr_i,
    input  logic d_i,
    output logic q_o
);

    // Storage cell with asynchronous set (dominant) and clear
    always_ff @(posedge clk_i or posedge set_i or posedge clr_i) begin
        if (set_i)      q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
        else            q_o <= d_i;
    end

endmodule

// File: rtl/dcnt_term.sv
module dcnt_term #(
    parameter int W = 8
) (
    input  logic [W-1:0] count_i,
    input  logic         cen_n_i,
    output logic         zero_n_o
);

    logic at_zero;

    always_comb begin
        at_zero  = (count_i == '0);
        zero_n_o = ~(at_zero & ~cen_n_i);
    end

endmodule

// File: rtl/dcnt_core.sv
module dcnt_core
    import dcnt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         mrst_n_i,
    input  logic         apre_n_i,
    input  logic         spre_n_i,
    input  logic         cen_n_i,
    input  logic [W-1:0] jam_i,
    output logic [W-1:0] count_o,
    output logic         zero_n_o
);

    localparam logic [W-1:0] STEP = W'(1);

    dcnt_mode_e   mode;
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;
    logic [W-1:0] bit_set;
    logic [W-1:0] bit_clr;

    dcnt_mode_dec u_dec (
        .mrst_n_i (mrst_n_i),
        .apre_n_i (apre_n_i),
        .spre_n_i (spre_n_i),
        .cen_n_i  (cen_n_i),
        .mode_o   (mode)
    );

    // Value taken at the next rising edge; async modes override it anyway
    always_comb begin
        unique case (mode)
            MD_CLEAR: cnt_d = '1;
            MD_APRE:  cnt_d = jam_i;
            MD_SPRE:  cnt_d = jam_i;
            MD_COUNT: cnt_d = cnt_q - STEP;
            MD_HOLD:  cnt_d = cnt_q;
            default:  cnt_d = cnt_q;
        endcase
    end

    // Per-bit asynchronous forcing: reset sets every bit, preset copies jam
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            always_comb begin
                bit_set[i] = ~mrst_n_i | (~apre_n_i & jam_i[i]);
                bit_clr[i] = mrst_n_i & ~apre_n_i & ~jam_i[i];
            end

            dcnt_bit u_bit (
                .clk_i (clk_i),
                .set_i (bit_set[i]),
                .clr_i (bit_clr[i]),
                .d_i   (cnt_d[i]),
                .q_o   (cnt_q[i])
            );
        end
    endgenerate

    dcnt_term #(.W(W)) u_term (
        .count_i  (cnt_q),
        .cen_n_i  (cen_n_i),
        .zero_n_o (zero_n_o)
    );

    assign count_o = cnt_q;

endmodule

// File: rtl/dcnt_chk.sv
module dcnt_chk #(
    parameter int W = 8
) (
    input logic         clk_i,
    input logic         mrst_n_i,
    input logic         apre_n_i,
    input logic         spre_n_i,
    input logic         cen_n_i,
    input logic [W-1:0] jam_i,
    input logic [W-1:0] count_o,
    input logic         zero_n_o
);

    localparam logic [W-1:0] TOP = '1;
    localparam logic [W-1:0] ONE = W'(1);

    p_count_r1: assert property (@(posedge clk_i) disable iff (!mrst_n_i)
        ($past(mrst_n_i) && $past(apre_n_i) && apre_n_i && $past(spre_n_i) && !$past(cen_n_i))
        |-> count_o == $past(count_o) - ONE);

    p_hold_r2: assert property (@(posedge clk_i) disable iff (!mrst_n_i)
        ($past(mrst_n_i) && $past(apre_n_i) && apre_n_i && $past(spre_n_i) && $past(cen_n_i))
        |-> $stable(count_o));

    p_sload_r3: assert property (@(posedge clk_i) disable iff (!mrst_n_i)
        ($past(mrst_n_i) && $past(apre_n_i) && apre_n_i && !$past(spre_n_i))
        |-> count_o == $past(jam_i));

    p_aload_r4: assert property (@(posedge clk_i) disable iff (!mrst_n_i)
        !apre_n_i |-> count_o == jam_i);

    p_clear_r5: assert property (@(posedge clk_i)
        !mrst_n_i |-> count_o == TOP);

    p_prio_r6: assert property (@(posedge clk_i) disable iff (!mrst_n_i)
        (!apre_n_i && !spre_n_i && !cen_n_i) |-> count_o == jam_i);

    p_tc_zero_r7: assert property (@(posedge clk_i)
        !zero_n_o |-> (count_o == '0 && !cen_n_i));

    p_tc_width_r7: assert property (@(posedge clk_i) disable iff (!mrst_n_i)
        (!zero_n_o && spre_n_i && apre_n_i) |=> (zero_n_o || !apre_n_i));

    p_wrap_r8: assert property (@(posedge clk_i) disable iff (!mrst_n_i)
        ($past(mrst_n_i) && $past(apre_n_i) && apre_n_i && $past(spre_n_i)
         && !$past(cen_n_i) && $past(count_o) == '0)
        |-> count_o == TOP);

endmodule

bind dcnt_core dcnt_chk #(.W(W)) u_chk (
    .clk_i    (clk_i),
    .mrst_n_i (mrst_n_i),
    .apre_n_i (apre_n_i),
    .spre_n_i (spre_n_i),
    .cen_n_i  (cen_n_i),
    .jam_i    (jam_i),
    .count_o  (count_o),
    .zero_n_o (zero_n_o)
);

// File: tb/sim_dcnt_core.sv
`timescale 1ns/1ps
module sim_dcnt_core;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         mrst_n = 1'b0;
    logic         apre_n = 1'b1;
    logic         spre_n = 1'b1;
    logic         cen_n = 1'b1;
    logic [W-1:0] jam = '0;
    logic [W-1:0] cnt_lo;
    logic [W-1:0] cnt_hi;
    logic         tc_lo_n;
    logic         tc_hi_n;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    // Lower stage
    dcnt_core #(.W(W)) u0 (
        .clk_i (clk), .mrst_n_i (mrst_n), .apre_n_i (apre_n), .spre_n_i (spre_n),
        .cen_n_i (cen_n), .jam_i (jam), .count_o (cnt_lo), .zero_n_o (tc_lo_n)
    );

    // Upper stage enabled by the lower terminal count
    dcnt_core #(.W(W)) u1 (
        .clk_i (clk), .mrst_n_i (mrst_n), .apre_n_i (apre_n), .spre_n_i (spre_n),
        .cen_n_i (tc_lo_n), .jam_i (jam), .count_o (cnt_hi), .zero_n_o (tc_hi_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive on falling edge, let one rising edge pass, return at falling edge
    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk("R5 reset count", cnt_lo, 255);
        chk("R7 reset tc", tc_lo_n, 1);
        @(negedge clk);
        mrst_n = 1'b1;
        #1 chk("R5 after release", cnt_lo, 255);
    endtask

    task automatic t_count;
        cen_n = 1'b0;
        tick(3);
        chk("R1 three decrements", cnt_lo, 252);
        tick(1);
        chk("R1 fourth decrement", cnt_lo, 251);
    endtask

    task automatic t_hold;
        cen_n = 1'b1;
        tick(4);
        chk("R2 hold", cnt_lo, 251);
        chk("R7 tc high on hold", tc_lo_n, 1);
    endtask

    task automatic t_sync_load;
        spre_n = 1'b0;
        jam = 8'h5A;
        #2 chk("R3 no load before edge", cnt_lo, 251);
        tick(1);
        chk("R3 load with enable high", cnt_lo, 8'h5A);
        cen_n = 1'b0;
        jam = 8'h3C;
        tick(1);
        chk("R3 load with enable low", cnt_lo, 8'h3C);
        spre_n = 1'b1;
        tick(1);
        chk("R1 count after load", cnt_lo, 8'h3B);
    endtask

    task automatic t_async_load;
        cen_n = 1'b1;
        jam = 8'hA5;
        apre_n = 1'b0;
        #2 chk("R4 immediate load", cnt_lo, 8'hA5);
        jam = 8'h0F;
        #2 chk("R4 follows jam", cnt_lo, 8'h0F);
        @(negedge clk);
        spre_n = 1'b0;
        cen_n = 1'b0;
        jam = 8'h80;
        #2 chk("R9 msb position", cnt_lo, 128);
        jam = 8'h0F;
        tick(1);
        chk("R6 async over sync/count", cnt_lo, 8'h0F);
        apre_n = 1'b1;
        spre_n = 1'b1;
        tick(1);
        chk("R1 count after async load", cnt_lo, 8'h0E);
    endtask

    task automatic t_reset_prio;
        apre_n = 1'b0;
        spre_n = 1'b0;
        jam = 8'h11;
        mrst_n = 1'b0;
        #2 chk("R6 reset over presets", cnt_lo, 255);
        tick(1);
        chk("R5 reset holds over edge", cnt_lo, 255);
        apre_n = 1'b1;
        spre_n = 1'b1;
        cen_n = 1'b1;
        tick(1);
        mrst_n = 1'b1;
        #1 chk("R5 still max", cnt_lo, 255);
    endtask

    task automatic t_terminal;
        int lows;
        spre_n = 1'b0;
        jam = 8'd2;
        cen_n = 1'b0;
        tick(1);
        spre_n = 1'b1;
        chk("R3 load 2", cnt_lo, 2);
        chk("R7 tc high at 2", tc_lo_n, 1);
        tick(2);
        chk("R1 reached zero", cnt_lo, 0);
        chk("R7 tc low at zero", tc_lo_n, 0);
        cen_n = 1'b1;
        #1 chk("R7 tc gated by enable", tc_lo_n, 1);
        tick(1);
        chk("R2 zero held", cnt_lo, 0);
        cen_n = 1'b0;
        #1 chk("R7 tc low again", tc_lo_n, 0);
        tick(1);
        chk("R8 wrap to max", cnt_lo, 255);
        chk("R7 tc released", tc_lo_n, 1);
        lows = 0;
        for (int i = 0; i < 256; i++) begin
            if (!tc_lo_n) lows++;
            tick(1);
        end
        chk("R8 one tc per 256 clocks", lows, 1);
        chk("R8 back to max after 256", cnt_lo, 255);
    endtask

    task automatic t_cascade;
        int model;
        int bad;
        cen_n = 1'b1;
        jam = 8'h01;
        apre_n = 1'b0;
        tick(1);
        apre_n = 1'b1;
        chk("R9 cascade preload", {cnt_hi, cnt_lo}, 16'h0101);
        cen_n = 1'b0;
        model = 16'h0101;
        bad = 0;
        for (int i = 0; i < 600; i++) begin
            tick(1);
            model = (model - 1) & 16'hFFFF;
            if ({cnt_hi, cnt_lo} != model[15:0]) bad++;
        end
        chk("R9 cascade mismatches", bad, 0);
        chk("R9 cascade value", {cnt_hi, cnt_lo}, (16'h0101 - 600) & 16'hFFFF);
    endtask

    initial begin
        tick(2);
        t_reset();
        t_count();
        t_hold();
        t_sync_load();
        t_async_load();
        t_reset_prio();
        t_terminal();
        t_cascade();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule